// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI master that performs exactly one flash transaction per start request. Software places the command byte in its own register, sets how many bytes follow it outbound and how many are expected back, and fills a shared byte buffer with the outbound bytes. Writing the start code then makes the engine pull chip select low and shift out the command byte followed by the outbound bytes. It then clocks in the requested reply bytes and releases chip select.

Reply bytes land in the same buffer right behind the outbound bytes, so software reads them from buffer offset (outbound count + k). A busy flag in the status word covers the whole transaction. A request whose outbound plus reply count exceeds the buffer size is refused and flagged in a sticky error bit. The serial clock idles low, data changes while it is low and is sampled on its rising edge, and bytes go most significant bit first.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0 and the status word (address 0x04) reads 0.
- R2: Register map: command byte at 0x00, outbound count at 0x01, reply count at 0x02, start register at 0x03, status at 0x04 (bit 0 busy, bit 1 error, other bits 0), buffer entry i at 0x80+i for i below 71. Written values read back unchanged.
- R3: Writing 0xA5 to address 0x03 while idle starts a transaction when outbound count + reply count is at most 71. Any other value written there starts nothing.
- R4: During a transaction, spi_mosi carries the command byte first, then buffer entries 0 to (outbound count - 1), each MSB first. Exactly 8 × (1 + outbound + reply) rising spi_sck edges occur, and spi_mosi never changes while spi_sck is high.
- R5: Reply byte k, sampled from spi_miso on rising spi_sck edges MSB first, is stored at buffer entry (outbound count + k). Entries 0 to outbound-1 are left unchanged, and spi_mosi is 0 throughout the reply bytes.
- R6: spi_cs_n goes low once per transaction and stays low until the end. Busy reads 1 from the first cycle after the start write, stays 1 whenever spi_cs_n is low, and reads 0 in the cycle spi_cs_n returns high.
- R7: One spi_sck period is CLK_DIV system clocks. The first rising edge comes CLK_DIV/2 clocks after spi_cs_n falls, and spi_cs_n rises CLK_DIV clocks after the last falling spi_sck edge.
- R8: A start write with outbound + reply above 71 sets the error bit and leaves spi_cs_n high and busy 0. A sum of exactly 71 is accepted.
- R9: The error bit stays set until a status write with bit 1 = 1 clears it. Other writes leave it set.
- R10: While busy, every bus write is ignored, including writes to the count and command registers, the buffer and the start register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register / buffer address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The transaction is run with only a command byte, with outbound and reply bytes mixed, with reply bytes and no outbound bytes, and with a request that fills the buffer exactly. Comparing these shows whether the reply offset follows the outbound count, and whether the outbound and reply phases are told apart on spi_mosi. A request one byte over the limit separates the accept boundary from the refuse path. Writes made while busy and a wrong start code show whether the engine's state can be disturbed outside an idle, correctly coded request. A responder in the bench drives a distinct byte pattern on every byte slot, so a shifted or reversed reply byte shows up in the buffer readback.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [7:0] ADR_OPCODE = 8'h00;
  localparam logic [7:0] ADR_TXCNT  = 8'h01;
  localparam logic [7:0] ADR_RXCNT  = 8'h02;
  localparam logic [7:0] ADR_START  = 8'h03;
  localparam logic [7:0] ADR_STATUS = 8'h04;
  localparam logic [7:0] START_CODE = 8'hA5;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_TAIL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
// Shared byte buffer: bus port (read/write) and engine port (read + reply write).
module spi_cmd_fifo #(
  parameter int DEPTH = 71,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  logic [7:0]       eng_wdata,
  input  logic [IDX_W-1:0] eng_ridx,
  output logic [7:0]       eng_rdata
);
  logic [7:0] mem [DEPTH];

  // Bus writes only happen when idle, engine writes only when busy.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (bus_we && (bus_idx == IDX_W'(i))) begin
        mem[i] <= bus_wdata;
      end else if (eng_we && (eng_widx == IDX_W'(i))) begin
        mem[i] <= eng_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = (32'(bus_idx) < DEPTH) ? mem[bus_idx] : 8'h00;
    eng_rdata = (32'(eng_ridx) < DEPTH) ? mem[eng_ridx] : 8'h00;
  end
endmodule

// File: rtl/spi_cmd_regs.sv
// Register file: command byte, counts, sticky error, start decode, read mux.
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 71,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  input  logic [7:0]       fifo_rdata,
  output logic             fifo_we,
  output logic [IDX_W-1:0] fifo_idx,
  output logic [7:0]       opcode,
  output logic [7:0]       tx_cnt,
  output logic [7:0]       rx_cnt,
  output logic             err,
  output logic             start
);
  localparam logic [8:0] LIMIT = 9'(DEPTH);

  logic [7:0] op_q, op_d, tx_q, tx_d, rx_q, rx_d;
  logic       err_q, err_d;
  logic       wr_ok, trig, too_big, in_buf;
  logic [6:0] off;
  logic [8:0] sum;

  always_comb begin
    off     = bus_addr[6:0];
    in_buf  = bus_addr[7] && (32'(off) < DEPTH);
    wr_ok   = bus_we && !busy;
    sum     = {1'b0, tx_q} + {1'b0, rx_q};
    too_big = sum > LIMIT;
    trig    = wr_ok && (bus_addr == ADR_START) && (bus_wdata == START_CODE);
    start   = trig && !too_big;
    fifo_we = wr_ok && in_buf;
    fifo_idx = off[IDX_W-1:0];
  end

  always_comb begin
    op_d  = op_q;
    tx_d  = tx_q;
    rx_d  = rx_q;
    err_d = err_q;
    if (wr_ok) begin
      case (bus_addr)
        ADR_OPCODE: op_d = bus_wdata;
        ADR_TXCNT:  tx_d = bus_wdata;
        ADR_RXCNT:  rx_d = bus_wdata;
        ADR_STATUS: if (bus_wdata[1]) err_d = 1'b0;
        default: ;
      endcase
    end
    if (trig && too_big) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= 8'h00;
      tx_q  <= 8'h00;
      rx_q  <= 8'h00;
      err_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_OPCODE: bus_rdata = {24'h0, op_q};
      ADR_TXCNT:  bus_rdata = {24'h0, tx_q};
      ADR_RXCNT:  bus_rdata = {24'h0, rx_q};
      ADR_STATUS: bus_rdata = {30'h0, err_q, busy};
      default:    bus_rdata = in_buf ? {24'h0, fifo_rdata} : 32'h0;
    endcase
  end

  assign opcode = op_q;
  assign tx_cnt = tx_q;
  assign rx_cnt = rx_q;
  assign err    = err_q;
endmodule

// File: rtl/spi_cmd_seq.sv
// Mode-0 shift sequencer: command byte, outbound bytes, reply bytes, CS tail.
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int IDX_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [7:0]       tx_cnt,
  input  logic [7:0]       rx_cnt,
  input  logic [7:0]       fifo_rdata,
  output logic [IDX_W-1:0] fifo_ridx,
  output logic             fifo_we,
  output logic [IDX_W-1:0] fifo_widx,
  output logic [7:0]       fifo_wdata,
  input  logic             miso,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  seq_state_e st_q, st_d;
  logic [DW-1:0] div_q, div_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    byte_q, byte_d, last_q, last_d;
  logic [7:0]    tsh_q, tsh_d, rsh_q, rsh_d;
  logic          in_q, in_d, sck_q, sck_d, cs_q, cs_d;
  logic          half_end, tail_end, is_rx;

  always_comb begin
    half_end   = (div_q == DW'(HALF - 1));
    tail_end   = (div_q == DW'(CLK_DIV - 1));
    is_rx      = (byte_q > tx_cnt);
    fifo_ridx  = byte_q[IDX_W-1:0];
    fifo_widx  = IDX_W'(byte_q - 8'd1);
    fifo_wdata = {rsh_q[6:0], in_q};
  end

  always_comb begin
    st_d    = st_q;
    div_d   = div_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    last_d  = last_q;
    tsh_d   = tsh_q;
    rsh_d   = rsh_q;
    in_d    = in_q;
    sck_d   = sck_q;
    cs_d    = cs_q;
    fifo_we = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d   = SQ_SHIFT;
          div_d  = '0;
          bit_d  = 3'd0;
          byte_d = 8'd0;
          last_d = tx_cnt + rx_cnt;
          tsh_d  = opcode;
          cs_d   = 1'b0;
          sck_d  = 1'b0;
        end
      end
      SQ_SHIFT: begin
        if (!half_end) begin
          div_d = div_q + DW'(1);
        end else begin
          div_d = '0;
          if (!sck_q) begin
            sck_d = 1'b1;
            in_d  = miso;
          end else begin
            sck_d = 1'b0;
            rsh_d = {rsh_q[6:0], in_q};
            if (bit_q == 3'd7) begin
              bit_d   = 3'd0;
              fifo_we = is_rx;
              if (byte_q == last_q) begin
                st_d = SQ_TAIL;
              end else begin
                byte_d = byte_q + 8'd1;
                tsh_d  = (byte_q < tx_cnt) ? fifo_rdata : 8'h00;
              end
            end else begin
              bit_d = bit_q + 3'd1;
              tsh_d = {tsh_q[6:0], 1'b0};
            end
          end
        end
      end
      SQ_TAIL: begin
        if (tail_end) begin
          st_d  = SQ_IDLE;
          div_d = '0;
          cs_d  = 1'b1;
        end else begin
          div_d = div_q + DW'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      div_q  <= '0;
      bit_q  <= 3'd0;
      byte_q <= 8'd0;
      last_q <= 8'd0;
      tsh_q  <= 8'h00;
      rsh_q  <= 8'h00;
      in_q   <= 1'b0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      last_q <= last_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
      in_q   <= in_d;
      sck_q  <= sck_d;
      cs_q   <= cs_d;
    end
  end

  assign busy = (st_q != SQ_IDLE);
  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign mosi = cs_q ? 1'b0 : tsh_q[7];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int FIFO_DEPTH = 71,
  parameter int CLK_DIV    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int IDX_W = $clog2(FIFO_DEPTH);

  logic             busy, err, start;
  logic [7:0]       opcode, tx_cnt, rx_cnt;
  logic             bfifo_we, efifo_we;
  logic [IDX_W-1:0] bfifo_idx, efifo_widx, efifo_ridx;
  logic [7:0]       bfifo_rdata, efifo_rdata, efifo_wdata;

  spi_cmd_regs #(.DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .fifo_rdata (bfifo_rdata),
    .fifo_we    (bfifo_we),
    .fifo_idx   (bfifo_idx),
    .opcode     (opcode),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .err        (err),
    .start      (start)
  );

  spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)) u_fifo (
    .clk       (clk),
    .bus_we    (bfifo_we),
    .bus_idx   (bfifo_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bfifo_rdata),
    .eng_we    (efifo_we),
    .eng_widx  (efifo_widx),
    .eng_wdata (efifo_wdata),
    .eng_ridx  (efifo_ridx),
    .eng_rdata (efifo_rdata)
  );

  spi_cmd_seq #(.CLK_DIV(CLK_DIV), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .fifo_rdata (efifo_rdata),
    .fifo_ridx  (efifo_ridx),
    .fifo_we    (efifo_we),
    .fifo_widx  (efifo_widx),
    .fifo_wdata (efifo_wdata),
    .miso       (spi_miso),
    .busy       (busy),
    .sck        (spi_sck),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 71
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic       busy,
  input logic       err,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] tx_cnt,
  input logic [7:0] rx_cnt
);
  logic [8:0] req_sum;
  assign req_sum = {1'b0, tx_cnt} + {1'b0, rx_cnt};

  // R1
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R6
  cs_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R4
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R8
  oversize_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !busy && bus_addr == ADR_START && bus_wdata == START_CODE
     && req_sum > 9'(DEPTH)) |=> (err && !busy));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(bus_we && !busy && bus_addr == ADR_STATUS && bus_wdata[1])) |=> err);

  // R10
  busy_count_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == ADR_TXCNT) |=> $stable(tx_cnt));
endmodule

bind spi_cmd_engine spi_cmd_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck       (spi_sck),
  .cs_n      (spi_cs_n),
  .mosi      (spi_mosi),
  .busy      (busy),
  .err       (err),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int DEPTH = 71;
  localparam logic [7:0] A_OP = 8'h00, A_TX = 8'h01, A_RX = 8'h02,
                         A_GO = 8'h03, A_ST = 8'h04;

  logic clk, rst_n, bus_we, spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic [7:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata;
  int total, bad;
  int sck_falls, sck_rises, cs_falls, fall_base;
  bit mosi_bits [1024];

  spi_cmd_engine #(.FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] resp_byte(input int j);
    return 8'(j * 59) ^ 8'h5C;
  endfunction
  function automatic logic [7:0] tx_byte(input int i);
    return 8'(i * 29 + 17);
  endfunction

  // Flash responder model, mode 0
  initial begin sck_falls = 0; sck_rises = 0; cs_falls = 0; fall_base = 0; end
  always @(negedge spi_sck) sck_falls++;
  always @(negedge spi_cs_n) begin cs_falls++; fall_base = sck_falls; end
  always @(posedge spi_sck) begin
    int bp;
    bp = sck_falls - fall_base;
    sck_rises++;
    if (bp < 1024) mosi_bits[bp] = spi_mosi;
  end
  always_comb begin
    int bp;
    logic [7:0] rb;
    bp = sck_falls - fall_base;
    rb = resp_byte(bp / 8);
    spi_miso = rb[7 - (bp % 8)];
  end

  function automatic logic [7:0] mosi_byte(input int j);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[7-b] = mosi_bits[8*j + b];
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "cs_n", 32'(spi_cs_n), 1);
    chk("R1", "sck", 32'(spi_sck), 0);
    chk("R1", "mosi", 32'(spi_mosi), 0);
    bus_read(A_ST, d);
    chk("R1", "status", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(A_OP, 8'h3B); bus_write(A_TX, 8'h05); bus_write(A_RX, 8'h07);
    bus_write(8'h80 + 8'(DEPTH-1), 8'hC7);
    bus_read(A_OP, d); chk("R2", "opcode readback", d, 32'h3B);
    bus_read(A_TX, d); chk("R2", "tx count readback", d, 32'h05);
    bus_read(A_RX, d); chk("R2", "rx count readback", d, 32'h07);
    bus_read(8'h80 + 8'(DEPTH-1), d); chk("R2", "last buffer entry", d, 32'hC7);
  endtask

  task automatic t_bad_code();
    int f0;
    logic [31:0] d;
    f0 = cs_falls;
    bus_write(A_GO, 8'h5A);
    repeat (20) @(negedge clk);
    chk("R3", "wrong start code cs falls", 32'(cs_falls - f0), 0);
    bus_read(A_ST, d); chk("R3", "wrong start code status", d, 0);
  endtask

  task automatic run_xfer(input logic [7:0] op, input int tx, input int rx);
    int p, first_rise, last_fall, cs_rise, gap, f0, r0, errs;
    logic prev;
    logic [31:0] d;
    bit done;
    bus_write(A_OP, op); bus_write(A_TX, 8'(tx)); bus_write(A_RX, 8'(rx));
    for (int i = 0; i < tx; i++) bus_write(8'h80 + 8'(i), tx_byte(i));
    f0 = cs_falls; r0 = sck_rises;
    bus_write(A_GO, 8'hA5);
    bus_addr = A_ST; #1;
    chk("R6", "busy after start", 32'(bus_rdata[0]), 1);
    p = 0; first_rise = -1; last_fall = -1; cs_rise = -1; gap = 0; prev = 1'b0; done = 0;
    while (!done && p < 20000) begin
      if (!spi_cs_n && !bus_rdata[0]) gap++;
      if (spi_sck && first_rise < 0) first_rise = p;
      if (!spi_sck && prev) last_fall = p;
      if (spi_cs_n) begin
        cs_rise = p; done = 1;
        chk("R6", "busy clear at cs release", 32'(bus_rdata[0]), 0);
      end
      prev = spi_sck;
      if (!done) begin @(negedge clk); #1; p++; end
    end
    chk("R6", "busy low while cs low", 32'(gap), 0);
    chk("R6", "single cs assertion", 32'(cs_falls - f0), 1);
    chk("R7", "first rise delay", 32'(first_rise), 32'(DIV/2));
    chk("R7", "cs tail after last fall", 32'(cs_rise - last_fall), 32'(DIV));
    chk("R4", "sck rising count", 32'(sck_rises - r0), 32'(8*(1+tx+rx)));
    chk("R4", "opcode on mosi", 32'(mosi_byte(0)), 32'(op));
    errs = 0;
    for (int i = 0; i < tx; i++) if (mosi_byte(1+i) !== tx_byte(i)) errs++;
    chk("R4", "outbound bytes on mosi", 32'(errs), 0);
    errs = 0;
    for (int k = 0; k < rx; k++) if (mosi_byte(1+tx+k) !== 8'h00) errs++;
    chk("R5", "mosi zero in reply phase", 32'(errs), 0);
    errs = 0;
    for (int k = 0; k < rx; k++) begin
      bus_read(8'h80 + 8'(tx+k), d);
      if (d[7:0] !== resp_byte(1+tx+k)) errs++;
    end
    chk("R5", "reply bytes at tx offset", 32'(errs), 0);
    errs = 0;
    for (int i = 0; i < tx; i++) begin
      bus_read(8'h80 + 8'(i), d);
      if (d[7:0] !== tx_byte(i)) errs++;
    end
    chk("R5", "outbound entries kept", 32'(errs), 0);
    @(negedge clk);
  endtask

  task automatic t_oversize();
    int f0;
    logic [31:0] d;
    f0 = cs_falls;
    bus_write(A_TX, 8'd40); bus_write(A_RX, 8'd32);
    bus_write(A_GO, 8'hA5);
    bus_read(A_ST, d); chk("R8", "oversize sets error, not busy", d, 32'h2);
    repeat (10) @(negedge clk);
    chk("R8", "oversize no cs", 32'(cs_falls - f0), 0);
    bus_write(A_ST, 8'h00);
    bus_read(A_ST, d); chk("R9", "error kept on status write 0", d, 32'h2);
    bus_write(A_OP, 8'h11);
    bus_read(A_ST, d); chk("R9", "error kept on other write", d, 32'h2);
    bus_write(A_ST, 8'h02);
    bus_read(A_ST, d); chk("R9", "error cleared", d, 32'h0);
  endtask

  task automatic t_busy_lock();
    int f0, n;
    logic [31:0] d;
    bus_write(A_OP, 8'h9F); bus_write(A_TX, 8'd1); bus_write(A_RX, 8'd2);
    bus_write(8'h80, 8'h33);
    f0 = cs_falls;
    bus_write(A_GO, 8'hA5);
    repeat (3) @(negedge clk);
    bus_write(A_TX, 8'd9);
    bus_write(8'h80, 8'hEE);
    bus_write(A_OP, 8'h00);
    bus_write(A_GO, 8'hA5);
    n = 0;
    while (!spi_cs_n && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    bus_read(A_TX, d); chk("R10", "tx count locked", d, 32'd1);
    bus_read(A_OP, d); chk("R10", "opcode locked", d, 32'h9F);
    bus_read(8'h80, d); chk("R10", "buffer entry locked", d, 32'h33);
    chk("R10", "second start ignored", 32'(cs_falls - f0), 1);
    chk("R10", "outbound byte on wire", 32'(mosi_byte(1)), 32'h33);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL R6 watchdog actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bad_code();
    run_xfer(8'hAB, 0, 0);
    run_xfer(8'h0B, 3, 4);
    run_xfer(8'h9F, 0, 5);
    t_oversize();
    run_xfer(8'h03, 40, 31);
    begin
      logic [31:0] d;
      bus_read(A_ST, d); chk("R8", "full-size request no error", d, 0);
    end
    t_busy_lock();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule